// File: doc/BRIEF.md
# Step/Direction Microstep Indexer

This block turns a step-pulse and direction interface into digital current setpoints for the two windings of a bipolar two-phase stepper motor. It keeps a 6-bit electrical phase index, giving 64 positions per electrical cycle. Each accepted rising edge on the step input moves the index by a stride that depends on the selected step resolution, in the direction set by the direction level. The new index is converted into signed setpoints for winding A (cosine) and winding B (sine), and those setpoints are scaled by a torque setting.

The resolution is chosen by two three-level select pins. The torque setting comes from one three-level pin. Each three-level pin reaches the block as a value bit plus a floating flag. A two-bit decay selection is captured at the moment the bridges become enabled and is then held. A four-state controller sequences the block. In SLEEP the block is in low power and the bridges are off. WAKE loads the home position. HOLD means awake with the bridges disabled. DRIVE means the bridges are enabled and steps are accepted. The transitions are: SLEEP→WAKE when the sleep input is released; WAKE→DRIVE or WAKE→HOLD according to enable; HOLD↔DRIVE as enable changes; and any state→SLEEP when the sleep input is pulled low. An active-low fault output follows the OR of the fault inputs.

Top module: `stepper_indexer`

## Requirements
- R1: A rising edge on `step_in` is synchronised and moves the index exactly once, in DRIVE only. Holding `step_in` high produces no further step. The index is updated, and `setpoint_upd` pulses for one cycle, three clock edges after `step_in` is first sampled high.
- R2: When `dir_in` is 1 at the step edge, the index increases by the stride. When it is 0, the index decreases by the stride. Both directions wrap modulo 64.
- R3: The stride comes from the select pins. Each pin is low, high or open, and a pin is open when its `_z` flag is 1. (m0 low, m1 low) gives stride 16. (m0 high, m1 low) gives 1. (m0 low, m1 high) gives 8. (m0 high, m1 high) gives 4. (m0 open, m1 low) gives 2. Every other combination gives 16. The pins are read only at the step edge.
- R4: At full torque, `coil_a_set` = round(255·cos(2π·i/64)) and `coil_b_set` = round(255·sin(2π·i/64)), where i is the index. Both are 9-bit two's complement values.
- R5: `decay_mode` takes `decay_sel` on the cycle the block enters DRIVE and holds it otherwise.
- R6: `bridge_en` is 1 only in DRIVE. One cycle after `enable_in` goes low, `bridge_en` is 0, and step edges are ignored while it stays low.
- R7: One cycle after `sleep_n_in` goes low, `asleep` is 1 and step edges are ignored. Releasing sleep passes through WAKE. WAKE sets the index to 8 and both setpoints to 180 at full torque, and pulses `setpoint_upd`.
- R8: The torque pin (`trq_val`, `trq_z`) scales the setpoint magnitude before the sign is applied. Low gives the magnitude unchanged. High gives floor(3·m/4). Open gives floor(m/2). The pin is read at each setpoint update.
- R9: One cycle after any bit of `fault_in` is 1, `fault_n` is 0. It returns to 1 one cycle after all bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_in | input | 1 | Step pulse, asynchronous |
| dir_in | input | 1 | Direction level |
| enable_in | input | 1 | Bridge enable |
| sleep_n_in | input | 1 | Low selects sleep |
| m0_val | input | 1 | Select pin 0 level |
| m0_z | input | 1 | Select pin 0 floating flag |
| m1_val | input | 1 | Select pin 1 level |
| m1_z | input | 1 | Select pin 1 floating flag |
| trq_val | input | 1 | Torque pin level |
| trq_z | input | 1 | Torque pin floating flag |
| decay_sel | input | 2 | Decay choice, captured on enable |
| fault_in | input | FAULT_W | Fault conditions, active high |
| phase_idx | output | 6 | Electrical phase index |
| coil_a_set | output | 9 | Winding A signed setpoint |
| coil_b_set | output | 9 | Winding B signed setpoint |
| setpoint_upd | output | 1 | One-cycle pulse on setpoint change |
| decay_mode | output | 2 | Latched decay choice |
| bridge_en | output | 1 | Bridge enable |
| asleep | output | 1 | Low-power state indicator |
| fault_n | output | 1 | Active-low fault |

## Verification
Several properties are checked on every cycle: the index never moves without an update pulse, the bridges drop after enable falls, sleep is entered after the sleep input falls, the decay value changes only when the bridges turn on, a detected edge never repeats on the next cycle, and a fault drives the fault output low. The numeric setpoint values, the stride table, wrap-around in both directions, torque scaling, the home load on wake and the ignoring of steps while disabled or asleep can only be shown by the bench scenarios. The bench compares a scoreboard of expected index and setpoint triples against every update pulse.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int PHASE_W = 6;
    localparam int MAG_W   = 8;
    localparam int QTR_W   = PHASE_W - 2;
    localparam int QTR     = 1 << QTR_W;

    typedef enum logic [1:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_HOLD,
        ST_DRIVE
    } idx_state_t;

    typedef enum logic [1:0] {
        LVL_LOW,
        LVL_HIGH,
        LVL_OPEN
    } tri_lvl_t;

    function automatic tri_lvl_t tri_decode(input logic val, input logic z);
        if (z)        return LVL_OPEN;
        else if (val) return LVL_HIGH;
        else          return LVL_LOW;
    endfunction

    // quarter-wave magnitude, 255 * sin(k * 90deg / 16), k = 0..16
    function automatic logic [MAG_W-1:0] qsin(input logic [QTR_W:0] k);
        logic [MAG_W-1:0] m;
        case (k)
            5'd0:  m = 8'd0;
            5'd1:  m = 8'd25;
            5'd2:  m = 8'd50;
            5'd3:  m = 8'd74;
            5'd4:  m = 8'd98;
            5'd5:  m = 8'd120;
            5'd6:  m = 8'd142;
            5'd7:  m = 8'd162;
            5'd8:  m = 8'd180;
            5'd9:  m = 8'd197;
            5'd10: m = 8'd212;
            5'd11: m = 8'd225;
            5'd12: m = 8'd236;
            5'd13: m = 8'd244;
            5'd14: m = 8'd250;
            5'd15: m = 8'd254;
            default: m = 8'd255;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/step_edge_detect.sv
module step_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], async_in};
    end

    assign rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

    // one edge per transition, never two in a row
    p_single_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/step_mode_decode.sv
module step_mode_decode
    import stepper_pkg::*;
(
    input  logic               m0_val,
    input  logic               m0_z,
    input  logic               m1_val,
    input  logic               m1_z,
    output logic [PHASE_W-1:0] stride
);
    tri_lvl_t l0, l1;

    always_comb begin
        l0 = tri_decode(m0_val, m0_z);
        l1 = tri_decode(m1_val, m1_z);
        stride = PHASE_W'(QTR);                 // fallback: full step (R3)
        if (l1 == LVL_LOW) begin
            unique case (l0)
                LVL_LOW:  stride = PHASE_W'(QTR);
                LVL_HIGH: stride = PHASE_W'(1);
                LVL_OPEN: stride = PHASE_W'(2);
                default:  stride = PHASE_W'(QTR);
            endcase
        end else if (l1 == LVL_HIGH) begin
            unique case (l0)
                LVL_LOW:  stride = PHASE_W'(QTR / 2);
                LVL_HIGH: stride = PHASE_W'(QTR / 4);
                default:  stride = PHASE_W'(QTR);
            endcase
        end
    end

endmodule

// File: rtl/phase_to_current.sv
module phase_to_current
    import stepper_pkg::*;
(
    input  logic               [PHASE_W-1:0] phase,
    input  tri_lvl_t                         torque,
    output logic signed        [MAG_W:0]     set_a,
    output logic signed        [MAG_W:0]     set_b
);
    logic signed [MAG_W:0] set_w [2];

    for (genvar w = 0; w < 2; w++) begin : g_winding
        // winding A leads by a quarter cycle (cosine), winding B is the sine
        localparam logic [PHASE_W-1:0] OFS = (w == 0) ? PHASE_W'(QTR) : '0;
        logic [PHASE_W-1:0] idx;
        logic [QTR_W:0]     k;
        logic [MAG_W-1:0]   mag;
        logic [MAG_W+1:0]   mag3;
        logic [MAG_W-1:0]   scaled;

        always_comb begin
            idx  = phase + OFS;
            k    = idx[QTR_W] ? (QTR_W+1)'(QTR) - {1'b0, idx[QTR_W-1:0]}
                              : {1'b0, idx[QTR_W-1:0]};
            mag  = qsin(k);
            mag3 = {2'b00, mag} + {1'b0, mag, 1'b0};
            unique case (torque)
                LVL_HIGH: scaled = mag3[MAG_W+1:2];
                LVL_OPEN: scaled = mag >> 1;
                default:  scaled = mag;
            endcase
            set_w[w] = idx[PHASE_W-1] ? -$signed({1'b0, scaled})
                                      :  $signed({1'b0, scaled});
        end
    end

    assign set_a = set_w[0];
    assign set_b = set_w[1];

endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
    import stepper_pkg::*;
#(
    parameter int FAULT_W  = 3,
    parameter int HOME_IDX = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_in,
    input  logic                  dir_in,
    input  logic                  enable_in,
    input  logic                  sleep_n_in,
    input  logic                  m0_val,
    input  logic                  m0_z,
    input  logic                  m1_val,
    input  logic                  m1_z,
    input  logic                  trq_val,
    input  logic                  trq_z,
    input  logic [1:0]            decay_sel,
    input  logic [FAULT_W-1:0]    fault_in,
    output logic [PHASE_W-1:0]    phase_idx,
    output logic signed [MAG_W:0] coil_a_set,
    output logic signed [MAG_W:0] coil_b_set,
    output logic                  setpoint_upd,
    output logic [1:0]            decay_mode,
    output logic                  bridge_en,
    output logic                  asleep,
    output logic                  fault_n
);
    localparam logic [PHASE_W-1:0] HOME = PHASE_W'(HOME_IDX);

    idx_state_t            state_q, state_nx;
    logic                  step_rise;
    logic [PHASE_W-1:0]    stride;
    logic [PHASE_W-1:0]    phase_q, phase_nx;
    logic signed [MAG_W:0] lut_a, lut_b;
    logic signed [MAG_W:0] a_q, b_q;
    logic                  upd_q, load_nx;
    logic [1:0]            decay_q;
    logic                  fault_q;
    logic                  adv, enter_drive;

    step_edge_detect #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (step_in),
        .rise     (step_rise)
    );

    step_mode_decode u_mode (
        .m0_val (m0_val),
        .m0_z   (m0_z),
        .m1_val (m1_val),
        .m1_z   (m1_z),
        .stride (stride)
    );

    phase_to_current u_lut (
        .phase  (phase_nx),
        .torque (tri_decode(trq_val, trq_z)),
        .set_a  (lut_a),
        .set_b  (lut_b)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SLEEP: if (sleep_n_in) state_nx = ST_WAKE;
            ST_WAKE:  if (!sleep_n_in)     state_nx = ST_SLEEP;
                      else if (enable_in)  state_nx = ST_DRIVE;
                      else                 state_nx = ST_HOLD;
            ST_HOLD:  if (!sleep_n_in)     state_nx = ST_SLEEP;
                      else if (enable_in)  state_nx = ST_DRIVE;
            ST_DRIVE: if (!sleep_n_in)     state_nx = ST_SLEEP;
                      else if (!enable_in) state_nx = ST_HOLD;
            default:  state_nx = ST_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_nx;
    end

    // datapath control
    always_comb begin
        adv         = (state_q == ST_DRIVE) && (state_nx == ST_DRIVE) && step_rise;
        enter_drive = (state_nx == ST_DRIVE) && (state_q != ST_DRIVE);
        load_nx     = adv || (state_q == ST_WAKE);
        phase_nx    = phase_q;
        if (state_q == ST_WAKE)  phase_nx = HOME;
        else if (adv)            phase_nx = dir_in ? phase_q + stride : phase_q - stride;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= HOME;
            a_q     <= '0;
            b_q     <= '0;
            upd_q   <= 1'b0;
            decay_q <= '0;
            fault_q <= 1'b0;
        end else begin
            phase_q <= phase_nx;
            upd_q   <= load_nx;
            if (load_nx) begin
                a_q <= lut_a;
                b_q <= lut_b;
            end
            if (enter_drive) decay_q <= decay_sel;
            fault_q <= |fault_in;
        end
    end

    // outputs
    always_comb begin
        bridge_en    = (state_q == ST_DRIVE);
        asleep       = (state_q == ST_SLEEP);
        phase_idx    = phase_q;
        coil_a_set   = a_q;
        coil_b_set   = b_q;
        setpoint_upd = upd_q;
        decay_mode   = decay_q;
        fault_n      = ~fault_q;
    end

    p_phase_moves_with_upd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_idx) |-> setpoint_upd);

    p_decay_only_on_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(decay_mode) |-> $rose(bridge_en));

    p_bridge_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_in |=> !bridge_en);

    p_enter_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n_in |=> (asleep && !bridge_en));

    p_fault_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> !fault_n);

endmodule

// File: tb/tb_stepper_indexer.sv
module tb_stepper_indexer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 0, dir_in = 0, enable_in = 0, sleep_n_in = 0;
    logic m0_val = 0, m0_z = 0, m1_val = 0, m1_z = 0, trq_val = 0, trq_z = 0;
    logic [1:0] decay_sel = 0;
    logic [2:0] fault_in = 0;
    logic [5:0] phase_idx;
    logic signed [8:0] coil_a_set, coil_b_set;
    logic setpoint_upd, bridge_en, asleep, fault_n;
    logic [1:0] decay_mode;

    int errors = 0;
    int checks = 0;
    int model_phase = 8;
    int trq_lvl = 0;
    int q_phase[$];
    int q_a[$];
    int q_b[$];
    string q_tag[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    stepper_indexer #(.FAULT_W(3), .HOME_IDX(8)) dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .enable_in(enable_in), .sleep_n_in(sleep_n_in),
        .m0_val(m0_val), .m0_z(m0_z), .m1_val(m1_val), .m1_z(m1_z),
        .trq_val(trq_val), .trq_z(trq_z), .decay_sel(decay_sel), .fault_in(fault_in),
        .phase_idx(phase_idx), .coil_a_set(coil_a_set), .coil_b_set(coil_b_set),
        .setpoint_upd(setpoint_upd), .decay_mode(decay_mode), .bridge_en(bridge_en),
        .asleep(asleep), .fault_n(fault_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sin_ref(input int i);
        real v;
        v = 255.0 * $sin(2.0 * 3.14159265358979 * real'(i % 64) / 64.0);
        return int'($floor(v + 0.5));
    endfunction

    function automatic int scale_ref(input int v);
        int m, s;
        m = (v < 0) ? -v : v;
        if (trq_lvl == 1)      s = (3 * m) / 4;
        else if (trq_lvl == 2) s = m / 2;
        else                   s = m;
        return (v < 0) ? -s : s;
    endfunction

    // 0 = low, 1 = high, 2 = open
    task automatic set_mode(input int l0, input int l1);
        m0_z = (l0 == 2); m0_val = (l0 == 1);
        m1_z = (l1 == 2); m1_val = (l1 == 1);
    endtask

    task automatic set_trq(input int l);
        trq_lvl = l;
        trq_z = (l == 2); trq_val = (l == 1);
    endtask

    task automatic push_exp(input string tag);
        q_phase.push_back(model_phase);
        q_a.push_back(scale_ref(sin_ref(model_phase + 16)));
        q_b.push_back(scale_ref(sin_ref(model_phase)));
        q_tag.push_back(tag);
    endtask

    task automatic pulse_step();
        @(negedge clk) step_in = 1;
        repeat (5) @(negedge clk);
        step_in = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_step(input int dir, input int stride, input string tag);
        dir_in = dir[0];
        model_phase = (((model_phase + (dir != 0 ? stride : -stride)) % 64) + 64) % 64;
        push_exp(tag);
        pulse_step();
    endtask

    // monitor: compare each update against the scoreboard
    always @(negedge clk) begin
        if (rst_n && setpoint_upd) begin
            if (q_phase.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1/R6/R7 unexpected update: actual phase=%0d expected no update", phase_idx);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " phase"}, int'(phase_idx), q_phase.pop_front());
                check({t, " coil A"}, int'(coil_a_set), q_a.pop_front());
                check({t, " coil B"}, int'(coil_b_set), q_b.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R7 reset asleep", asleep, 1);
        check("R6 reset bridge off", bridge_en, 0);
        check("R9 reset no fault", fault_n, 1);
        check("R7 reset phase", phase_idx, 8);

        // wake with bridges disabled: home load
        push_exp("R7 wake home");
        sleep_n_in = 1;
        repeat (4) @(negedge clk);
        check("R7 awake", asleep, 0);
        check("R6 hold bridge off", bridge_en, 0);
        check("R7 home A", coil_a_set, 180);

        // step while disabled is ignored
        pulse_step();
        check("R6 step ignored disabled", phase_idx, 8);

        // enable: decay captured
        decay_sel = 2'd2;
        @(negedge clk) enable_in = 1;
        @(negedge clk);
        check("R6 bridge on", bridge_en, 1);
        check("R5 decay captured", decay_mode, 2);
        decay_sel = 2'd1;
        repeat (3) @(negedge clk);
        check("R5 decay held", decay_mode, 2);

        // full step forward with wrap
        set_mode(0, 0);
        for (int i = 0; i < 4; i++) do_step(1, 16, "R2 R3 full fwd");
        // 1/16 backward across zero
        set_mode(1, 0);
        for (int i = 0; i < 10; i++) do_step(0, 1, "R2 R3 R4 sixteenth back");
        set_mode(0, 1);
        for (int i = 0; i < 3; i++) do_step(1, 8, "R3 half");
        set_mode(1, 1);
        for (int i = 0; i < 3; i++) do_step(0, 4, "R3 quarter");
        set_mode(2, 0);
        for (int i = 0; i < 3; i++) do_step(1, 2, "R3 eighth");
        set_mode(2, 2);
        do_step(1, 16, "R3 unused code full");
        set_mode(1, 2);
        do_step(0, 16, "R3 unused code full");

        // torque scaling
        set_mode(1, 0);
        set_trq(1);
        for (int i = 0; i < 3; i++) do_step(1, 1, "R8 torque 75");
        set_trq(2);
        for (int i = 0; i < 3; i++) do_step(0, 1, "R8 torque 50");
        set_trq(0);
        do_step(1, 1, "R8 torque full");

        // long high step: one update only
        dir_in = 1;
        model_phase = (model_phase + 1) % 64;
        push_exp("R1 held step single");
        @(negedge clk) step_in = 1;
        repeat (40) @(negedge clk);
        step_in = 0;
        repeat (5) @(negedge clk);
        check("R1 held step single phase", phase_idx, model_phase);

        // fault
        fault_in = 3'b010;
        @(negedge clk);
        check("R9 fault low", fault_n, 0);
        fault_in = 3'b000;
        @(negedge clk);
        check("R9 fault released", fault_n, 1);

        // disable, re-enable with new decay
        enable_in = 0;
        @(negedge clk);
        check("R6 bridge off after disable", bridge_en, 0);
        pulse_step();
        check("R6 step ignored after disable", phase_idx, model_phase);
        check("R5 decay held while disabled", decay_mode, 2);
        decay_sel = 2'd3;
        @(negedge clk) enable_in = 1;
        @(negedge clk);
        check("R5 decay recaptured", decay_mode, 3);

        // sleep, ignored step, wake to home
        sleep_n_in = 0;
        @(negedge clk);
        check("R7 asleep", asleep, 1);
        check("R7 bridge off asleep", bridge_en, 0);
        pulse_step();
        check("R7 step ignored asleep", phase_idx, model_phase);
        model_phase = 8;
        set_trq(1);
        push_exp("R7 R8 wake home scaled");
        sleep_n_in = 1;
        repeat (4) @(negedge clk);
        check("R7 wake phase home", phase_idx, 8);
        check("R7 bridge back on", bridge_en, 1);

        repeat (5) @(negedge clk);
        check("R1 scoreboard drained", q_phase.size(), 0);
        finish_run();
    end

endmodule